// File: doc/BRIEF.md
# Card Command Issue Register Unit

This block holds the command registers of a card host controller. Software builds a 32-bit argument by writing two 16-bit halves. It sets the control, timeout and enable fields, and then writes the command register. That write starts a command. The unit raises a request to a card-side command engine and holds the command index, response kind and argument steady on that interface. It then waits for the engine's single-cycle completion pulse.

On completion the unit captures the response words, if the command expects any, and sets completion status bits. The status bits depend on the outcome of the command. Software clears them by writing ones. A soft-reset bit in a system control register returns every register to its default.

Top module: `cmd_regs_top`

## Requirements
- R1: Word 1 (argument low) replaces argument bits 15:0 and word 2 (argument high) replaces bits 31:16. The other half is kept. Both halves read back, and the full argument drives `eng_arg`.
- R2: A command register write (word 0) while the enable bit (control bit 11) is 0 is ignored: no request rises and the command readback is unchanged.
- R3: The control register (word 3) keeps bit 15 (bus width), bits 13:12 (mode), bit 11 (enable), bit 10 (byte order) and the clock divider in bits 9:0. Bit 14 reads 0.
- R4: The command timeout register (word 5) keeps only its low 8 bits. The data timeout register (word 6) keeps all 16 bits.
- R5: An accepted command write raises `eng_req` after the next clock edge. `eng_index` carries command bits 5:0 and `eng_rsp_type` carries command bits 10:8, where 0 means none, 1 short, 2 long register dump, 3 operating conditions and 6 published address. The written value reads back from word 0.
- R6: On completion without timeout, with a response kind other than 0, response word i (words 8 to 15) is loaded from `eng_rsp_data[16i+15:16i]`. On timeout, or with kind 0, the response words are kept.
- R7: Completion with timeout sets status bit 7 only. Completion of index 12 sets status bits 0 and 2. Any other completion sets status bit 0. `eng_req` falls after the completion edge.
- R8: Writing the status register (word 4) clears exactly the bits written as 1.
- R9: Writes to the response words and to the revision word (word 7) have no effect. The revision word reads the parameter `REV_VALUE`.
- R10: Writing word 16 with bit 2 set clears the argument, control, timeouts, command, status, response words and any outstanding request.
- R11: Word 17 always reads 1. Unmapped words read 0.
- R12: A command write while a request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| eng_req | output | 1 | Command outstanding to the engine |
| eng_index | output | 6 | Command index |
| eng_rsp_type | output | 3 | Expected response kind |
| eng_arg | output | 32 | Command argument |
| eng_done | input | 1 | Single-cycle completion pulse |
| eng_timeout | input | 1 | Completion ended in timeout (valid with eng_done) |
| eng_rsp_data | input | 128 | Response words, word 0 in the low 16 bits |

## Verification
The bench sweeps argument halves and control and timeout patterns. A design that wrote a whole argument from one half would corrupt the other half. A design that kept the wrong mask would show stray bits on readback. The bench issues commands with enable off and while busy. A unit that accepted these would raise a request or overwrite the command readback. It also runs a normal completion, a stop completion (index 12), a timeout and a no-response completion. Each must set exactly its status pattern and either capture or keep the response words. A wrong status encoding, or a capture on timeout, shows directly in the readback. Writes to the read-only words and a soft reset close the run.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int ADDR_W = 5;
  localparam int NUM_RSP = 8;

  localparam logic [ADDR_W-1:0] A_CMD  = 5'd0;
  localparam logic [ADDR_W-1:0] A_ARGL = 5'd1;
  localparam logic [ADDR_W-1:0] A_ARGH = 5'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd4;
  localparam logic [ADDR_W-1:0] A_CTO  = 5'd5;
  localparam logic [ADDR_W-1:0] A_DTO  = 5'd6;
  localparam logic [ADDR_W-1:0] A_REV  = 5'd7;
  localparam logic [ADDR_W-1:0] A_RSP0 = 5'd8;
  localparam logic [ADDR_W-1:0] A_SYSC = 5'd16;
  localparam logic [ADDR_W-1:0] A_SYSS = 5'd17;

  localparam int ST_DONE = 0;
  localparam int ST_STOP = 2;
  localparam int ST_TMO  = 7;
  localparam int SRST_BIT = 2;
  localparam int CTRL_EN_BIT = 11;
  localparam logic [5:0] STOP_INDEX = 6'd12;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_SHORT = 3'd1,
    RSP_LONG  = 3'd2,
    RSP_OCOND = 3'd3,
    RSP_ADDR  = 3'd6
  } rsp_kind_e;
endpackage

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmdreg_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sreset,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [31:0]       arg,
  output logic [15:0]       ctrl,
  output logic [7:0]        cto,
  output logic [15:0]       dto
);
  localparam logic [15:0] CTRL_MASK = 16'hBC00 | 16'((1 << DIV_W) - 1);

  logic [31:0] arg_q, arg_d;
  logic [15:0] ctrl_q, ctrl_d;
  logic [7:0]  cto_q, cto_d;
  logic [15:0] dto_q, dto_d;

  always_comb begin
    arg_d  = arg_q;
    ctrl_d = ctrl_q;
    cto_d  = cto_q;
    dto_d  = dto_q;
    if (sreset) begin
      arg_d  = '0;
      ctrl_d = '0;
      cto_d  = '0;
      dto_d  = '0;
    end else if (we) begin
      case (addr)
        A_ARGL: arg_d[15:0]  = wdata;
        A_ARGH: arg_d[31:16] = wdata;
        A_CTRL: ctrl_d       = wdata & CTRL_MASK;
        A_CTO:  cto_d        = wdata[7:0];
        A_DTO:  dto_d        = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q  <= '0;
      ctrl_q <= '0;
      cto_q  <= '0;
      dto_q  <= '0;
    end else begin
      arg_q  <= arg_d;
      ctrl_q <= ctrl_d;
      cto_q  <= cto_d;
      dto_q  <= dto_d;
    end
  end

  assign arg  = arg_q;
  assign ctrl = ctrl_q;
  assign cto  = cto_q;
  assign dto  = dto_q;

  // R1: a low-half write leaves the high half alone
  p_arg_keep_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_ARGL && !sreset) |=> $stable(arg_q[31:16]));
  // R1: a high-half write leaves the low half alone
  p_arg_keep_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_ARGH && !sreset) |=> $stable(arg_q[15:0]));
  // R10: soft reset clears the configuration
  p_sreset_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (arg_q == 32'd0 && ctrl_q == 16'd0 && dto_q == 16'd0));
endmodule

// File: rtl/cmd_issue.sv
module cmd_issue
  import cmdreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sreset,
  input  logic        cmd_we,
  input  logic        stat_we,
  input  logic [15:0] wdata,
  input  logic        enable,
  input  logic        eng_done,
  input  logic        eng_timeout,
  output logic        busy,
  output logic        finish,
  output logic [15:0] cmd_last,
  output logic [15:0] status
);
  logic [15:0] cmd_q, cmd_d;
  logic [15:0] stat_q, stat_d;
  logic        busy_q, busy_d;
  logic        accept;
  logic        is_stop;

  assign accept  = cmd_we && enable && !busy_q;
  assign finish  = busy_q && eng_done;
  assign is_stop = (cmd_q[5:0] == STOP_INDEX);

  always_comb begin
    cmd_d  = cmd_q;
    busy_d = busy_q;
    stat_d = stat_q;
    if (stat_we) stat_d = stat_d & ~wdata;
    if (accept) begin
      cmd_d  = wdata;
      busy_d = 1'b1;
    end
    if (finish) begin
      busy_d = 1'b0;
      if (eng_timeout) begin
        stat_d[ST_TMO] = 1'b1;
      end else begin
        stat_d[ST_DONE] = 1'b1;
        if (is_stop) stat_d[ST_STOP] = 1'b1;
      end
    end
    if (sreset) begin
      cmd_d  = '0;
      busy_d = 1'b0;
      stat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      stat_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
      stat_q <= stat_d;
    end
  end

  assign busy     = busy_q;
  assign cmd_last = cmd_q;
  assign status   = stat_q;

  // R2: command writes with the enable bit clear change nothing
  p_disabled_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !enable && !sreset) |=> $stable(cmd_q));
  // R12: command writes while busy change nothing
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy_q && !sreset) |=> $stable(cmd_q));
  // R7: timeout completion raises the timeout bit
  p_timeout_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && eng_timeout && !sreset) |=> stat_q[ST_TMO]);
  // R7: stop completion raises both bits
  p_stop_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !eng_timeout && is_stop && !sreset) |=> (stat_q[ST_DONE] && stat_q[ST_STOP]));
  // R5: the request falls after completion
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !sreset) |=> !busy_q);
endmodule

// File: rtl/rsp_store.sv
module rsp_store
  import cmdreg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sreset,
  input  logic                    load,
  input  logic [NUM_RSP*16-1:0]   rsp_in,
  output logic [NUM_RSP*16-1:0]   rsp_out
);
  logic [NUM_RSP*16-1:0] rsp_q;

  for (genvar i = 0; i < NUM_RSP; i++) begin : g_word
    logic [15:0] word_d;
    always_comb begin
      word_d = rsp_q[16*i +: 16];
      if (sreset)    word_d = '0;
      else if (load) word_d = rsp_in[16*i +: 16];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_q[16*i +: 16] <= '0;
      else        rsp_q[16*i +: 16] <= word_d;
    end
  end

  assign rsp_out = rsp_q;

  // R6/R9: without a load the response words hold
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sreset) |=> $stable(rsp_q));
endmodule

// File: rtl/cmd_regs_top.sv
module cmd_regs_top
  import cmdreg_pkg::*;
#(
  parameter int          DIV_W     = 10,
  parameter logic [15:0] REV_VALUE = 16'h0021
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [4:0]            reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  output logic                  eng_req,
  output logic [5:0]            eng_index,
  output logic [2:0]            eng_rsp_type,
  output logic [31:0]           eng_arg,
  input  logic                  eng_done,
  input  logic                  eng_timeout,
  input  logic [127:0]          eng_rsp_data
);
  logic        sreset;
  logic [31:0] arg;
  logic [15:0] ctrl;
  logic [7:0]  cto;
  logic [15:0] dto;
  logic        busy, finish;
  logic [15:0] cmd_last, status;
  logic [NUM_RSP*16-1:0] rsp;
  logic        rsp_load;

  assign sreset = reg_we && reg_addr == A_SYSC && reg_wdata[SRST_BIT];

  cmd_regfile #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .arg(arg), .ctrl(ctrl), .cto(cto), .dto(dto)
  );

  cmd_issue u_issue (
    .clk(clk), .rst_n(rst_n), .sreset(sreset),
    .cmd_we(reg_we && reg_addr == A_CMD),
    .stat_we(reg_we && reg_addr == A_STAT),
    .wdata(reg_wdata), .enable(ctrl[CTRL_EN_BIT]),
    .eng_done(eng_done), .eng_timeout(eng_timeout),
    .busy(busy), .finish(finish), .cmd_last(cmd_last), .status(status)
  );

  assign rsp_load = finish && !eng_timeout && (cmd_last[10:8] != RSP_NONE);

  rsp_store u_rsp (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .load(rsp_load),
    .rsp_in(eng_rsp_data), .rsp_out(rsp)
  );

  assign eng_req      = busy;
  assign eng_index    = cmd_last[5:0];
  assign eng_rsp_type = cmd_last[10:8];
  assign eng_arg      = arg;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr >= A_RSP0 && reg_addr < A_RSP0 + 5'(NUM_RSP)) begin
      reg_rdata = rsp[16*(reg_addr - A_RSP0) +: 16];
    end else begin
      case (reg_addr)
        A_CMD:  reg_rdata = cmd_last;
        A_ARGL: reg_rdata = arg[15:0];
        A_ARGH: reg_rdata = arg[31:16];
        A_CTRL: reg_rdata = ctrl;
        A_STAT: reg_rdata = status;
        A_CTO:  reg_rdata = {8'h00, cto};
        A_DTO:  reg_rdata = dto;
        A_REV:  reg_rdata = REV_VALUE;
        A_SYSS: reg_rdata = 16'h0001;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/cmd_regs_top_test.sv
`timescale 1ns/1ps
module cmd_regs_top_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [4:0]   reg_addr;
  logic [15:0]  reg_wdata;
  logic [15:0]  reg_rdata;
  logic         eng_req;
  logic [5:0]   eng_index;
  logic [2:0]   eng_rsp_type;
  logic [31:0]  eng_arg;
  logic         eng_done;
  logic         eng_timeout;
  logic [127:0] eng_rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [15:0] REV = 16'h0021;
  localparam logic [15:0] CMASK = 16'hBC00 | 16'h03FF;

  always #5 clk = ~clk;

  cmd_regs_top #(.DIV_W(10), .REV_VALUE(REV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req),
    .eng_index(eng_index), .eng_rsp_type(eng_rsp_type), .eng_arg(eng_arg),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .eng_rsp_data(eng_rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  task automatic complete(input logic tmo, input logic [127:0] data);
    @(negedge clk);
    eng_done = 1'b1; eng_timeout = tmo; eng_rsp_data = data;
    @(negedge clk);
    eng_done = 1'b0; eng_timeout = 1'b0;
  endtask

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] p;
    for (int i = 0; i < 8; i++) p[16*i +: 16] = 16'(seed * 16'h0101 + i * 16'h1111);
    return p;
  endfunction

  initial begin
    #150000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] p1;
    logic [127:0] p2;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    eng_done = 1'b0; eng_timeout = 1'b0; eng_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R9/R11 constants
    rd_check("R10 reset cmd", 5'd0, 16'h0);
    rd_check("R10 reset ctrl", 5'd3, 16'h0);
    rd_check("R10 reset status", 5'd4, 16'h0);
    rd_check("R9 rev value", 5'd7, REV);
    rd_check("R11 sysstat", 5'd17, 16'h0001);
    rd_check("R11 unmapped", 5'd20, 16'h0000);
    check("R5 reset req", {31'h0, eng_req}, 32'h0);

    // R1 argument halves sweep
    for (int i = 0; i < 8; i++) begin
      logic [15:0] lo, hi;
      lo = 16'(i * 16'h1357 + 16'h0011);
      hi = 16'(i * 16'h2468 + 16'h0f0f);
      wr(5'd1, lo);
      wr(5'd2, hi);
      rd_check("R1 arg low", 5'd1, lo);
      rd_check("R1 arg high", 5'd2, hi);
      check("R1 eng_arg", eng_arg, {hi, lo});
    end
    wr(5'd1, 16'hBEEF);
    check("R1 high kept", eng_arg, {16'(7 * 16'h2468 + 16'h0f0f), 16'hBEEF});
    wr(5'd2, 16'hCAFE);
    check("R1 low kept", eng_arg, 32'hCAFEBEEF);

    // R3 control mask sweep, R4 timeouts
    for (int b = 0; b < 16; b++) begin
      logic [15:0] v;
      v = 16'(1) << b;
      wr(5'd3, v);
      rd_check("R3 ctrl bit", 5'd3, v & CMASK);
      wr(5'd5, v);
      rd_check("R4 cto", 5'd5, v & 16'h00FF);
      wr(5'd6, v ^ 16'hA5A5);
      rd_check("R4 dto", 5'd6, v ^ 16'hA5A5);
    end

    // R2 command ignored while disabled
    wr(5'd3, 16'h0000);
    wr(5'd0, 16'h0105);
    @(negedge clk);
    check("R2 no req", {31'h0, eng_req}, 32'h0);
    rd_check("R2 cmd kept", 5'd0, 16'h0000);

    // R5 accepted command
    wr(5'd3, 16'h0800);
    wr(5'd0, 16'h0111);
    check("R5 req", {31'h0, eng_req}, 32'h1);
    check("R5 index", {26'h0, eng_index}, 32'd17);
    check("R5 type", {29'h0, eng_rsp_type}, 32'd1);
    rd_check("R5 cmd readback", 5'd0, 16'h0111);

    // R12 busy ignore
    wr(5'd0, 16'h0203);
    rd_check("R12 cmd kept", 5'd0, 16'h0111);
    check("R12 index kept", {26'h0, eng_index}, 32'd17);

    // normal completion with capture
    p1 = pattern(3);
    complete(1'b0, p1);
    check("R7 req dropped", {31'h0, eng_req}, 32'h0);
    rd_check("R7 done status", 5'd4, 16'h0001);
    for (int i = 0; i < 8; i++) rd_check("R6 rsp captured", 5'(8 + i), p1[16*i +: 16]);

    // R8 clear
    wr(5'd4, 16'h0001);
    rd_check("R8 cleared", 5'd4, 16'h0000);

    // stop command, then partial clear
    wr(5'd0, 16'h010C);
    p2 = pattern(9);
    complete(1'b0, p2);
    rd_check("R7 stop status", 5'd4, 16'h0005);
    wr(5'd4, 16'h0004);
    rd_check("R8 partial clear", 5'd4, 16'h0001);
    wr(5'd4, 16'hFFFF);

    // timeout completion, no capture
    wr(5'd0, 16'h0202);
    complete(1'b1, pattern(40));
    rd_check("R7 timeout status", 5'd4, 16'h0080);
    rd_check("R6 kept on timeout", 5'd8, p2[15:0]);
    rd_check("R6 kept on timeout hi", 5'd15, p2[127:112]);
    wr(5'd4, 16'hFFFF);

    // no-response kind, no capture
    wr(5'd0, 16'h0000);
    complete(1'b0, pattern(77));
    rd_check("R7 kind0 status", 5'd4, 16'h0001);
    rd_check("R6 kept on kind0", 5'd10, p2[47:32]);

    // R9 read-only words
    wr(5'd9, 16'h1234);
    wr(5'd7, 16'h5555);
    rd_check("R9 rsp ro", 5'd9, p2[31:16]);
    rd_check("R9 rev ro", 5'd7, REV);

    // R10 soft reset; bit 2 clear first has no effect
    wr(5'd16, 16'h0003);
    rd_check("R10 no reset without bit", 5'd3, 16'h0800);
    wr(5'd0, 16'h0101);
    wr(5'd16, 16'h0004);
    check("R10 req cleared", {31'h0, eng_req}, 32'h0);
    rd_check("R10 arg", 5'd2, 16'h0000);
    rd_check("R10 ctrl", 5'd3, 16'h0000);
    rd_check("R10 cto", 5'd5, 16'h0000);
    rd_check("R10 status", 5'd4, 16'h0000);
    rd_check("R10 cmd", 5'd0, 16'h0000);
    rd_check("R10 rsp", 5'd12, 16'h0000);
    rd_check("R11 sysstat after", 5'd17, 16'h0001);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule